// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire PHY management bus: it produces the management clock and shifts out clause-22 frames that read or write one 16-bit PHY register. A host presents a PHY address, a register address, write data and a read/write select, then pulses `start`. The block latches these inputs, raises `busy`, and on completion pulses `done` with the read result on `rd_data`. The data line is split into `mdio_o`, `mdio_oe` and `mdio_i` so that the tristate pad sits outside the block.

Every transaction opens with a run of driven ones so the PHY can lock onto the frame. A read sends a 16-bit command and then releases the line for 19 clocks, keeping the 16 bits that follow the turnaround pair. A write sends a 32-bit word and then gives two released clocks. The management clock half period is a count of system clocks worked out from the system clock period and a minimum half-period time, so the clock stays at or below 2.5 MHz when the default 200 ns is kept.

A read of register 1 that returns all ones or all zeros is taken as a sign that no PHY answers at that address, and `no_phy` reports this until the next transaction ends.

Top module: `mdio_master`

## Requirements
- R1: After reset `mdc`, `mdio_oe`, `busy`, `done`, `no_phy` are 0 and `rd_data` is 0; while idle `mdc` and `mdio_oe` stay 0.
- R2: Each transaction starts with PRE_LEN management clock cycles in which `mdio_oe`=1 and `mdio_o`=1.
- R3: For a read (`rd_wr`=1) the next 16 driven bits, MSB first, are 1,1,0,1,1,0, then `phy_addr[4:0]`, then `reg_addr[4:0]`.
- R4: After the read command, 19 clock cycles follow with `mdio_oe`=0; numbering the sampled bits 0 to 18 in order, `rd_data` is bits 2 to 17 with bit 2 as the MSB; `done` follows the 19th cycle.
- R5: For a write (`rd_wr`=0) the next 32 driven bits, MSB first, are 0,1,0,1, `phy_addr`, `reg_addr`, 1,0, `wr_data[15:0]`; then 2 cycles with `mdio_oe`=0, then `done`.
- R6: Every high and every low phase of `mdc` lasts HALF system clocks, HALF = ceil(MIN_HALF_NS / SYS_PERIOD_NS), at least 1.
- R7: `mdio_o` and `mdio_oe` change only while `mdc` is low; `mdio_i` is taken in the system clock edge that raises `mdc`.
- R8: `busy` is 1 from the cycle after an accepted `start` until `done`; `done` is a one-cycle pulse in the cycle `busy` returns to 0.
- R9: `start` while `busy` is ignored: the frame in progress and its result are unchanged.
- R10: At `done` of a read of register 1 with result 0xFFFF or 0x0000, `no_phy` becomes 1; at `done` of any other transaction it becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |
| no_phy | output | 1 | Last transaction was a read of register 1 giving all ones or all zeros |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data to drive on the management line |
| mdio_oe | output | 1 | Drive enable for the management line |
| mdio_i | input | 1 | Value seen on the management line |

## Verification
The hardest case to reach is the read window, where the result depends on exactly which management clock edge takes each PHY bit, so that an off-by-one in the window only shows up when the turnaround and trailing bits differ from the data next to them. The bench models a PHY that counts rising `mdc` edges and drives a distinct value in every released slot, including a low second turnaround bit and a high idle bit, so any shift of the window changes `rd_data`. A second `start` with different inputs is thrown in mid-frame to show that the latched frame runs on untouched.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int SYS_PERIOD_NS = 10,
  parameter int MIN_HALF_NS   = 200,
  parameter int PRE_LEN       = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_wr,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        no_phy,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int HALF_RAW = (MIN_HALF_NS + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS;
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int CW       = $clog2(HALF + 1);
  localparam int BMAX     = (PRE_LEN > 32) ? PRE_LEN : 32;
  localparam int BCW      = $clog2(BMAX);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_CMD, S_REL} state_t;

  state_t          state;
  logic [CW-1:0]   div_cnt;
  logic            hi_phase;
  logic [BCW-1:0]  bit_cnt;
  logic [31:0]     tx_sr;
  logic [18:0]     rx_sr;
  logic            rd_q;
  logic [4:0]      reg_q;
  logic            tick;
  logic [15:0]     rx_val;

  assign busy    = (state != S_IDLE);
  assign tick    = (div_cnt == CW'(HALF - 1));
  assign mdio_oe = (state == S_PRE) || (state == S_CMD);
  assign mdio_o  = (state == S_CMD) ? tx_sr[31] : 1'b1;
  assign rx_val  = rx_sr[16:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      div_cnt  <= '0;
      hi_phase <= 1'b0;
      bit_cnt  <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rd_q     <= 1'b0;
      reg_q    <= '0;
      mdc      <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      no_phy   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          rd_q     <= rd_wr;
          reg_q    <= reg_addr;
          tx_sr    <= rd_wr ? {4'b1101, 2'b10, phy_addr, reg_addr, 16'h0000}
                            : {2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wr_data};
          bit_cnt  <= BCW'(PRE_LEN - 1);
          div_cnt  <= '0;
          hi_phase <= 1'b0;
          mdc      <= 1'b0;
          state    <= S_PRE;
        end
      end else if (!tick) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!hi_phase) begin
          hi_phase <= 1'b1;
          mdc      <= 1'b1;
          if (state == S_REL && rd_q) rx_sr <= {rx_sr[17:0], mdio_i};
        end else begin
          hi_phase <= 1'b0;
          mdc      <= 1'b0;
          case (state)
            S_PRE: begin
              if (bit_cnt == '0) begin
                state   <= S_CMD;
                bit_cnt <= rd_q ? BCW'(15) : BCW'(31);
              end else bit_cnt <= bit_cnt - 1'b1;
            end
            S_CMD: begin
              tx_sr <= {tx_sr[30:0], 1'b0};
              if (bit_cnt == '0) begin
                state   <= S_REL;
                bit_cnt <= rd_q ? BCW'(18) : BCW'(1);
              end else bit_cnt <= bit_cnt - 1'b1;
            end
            S_REL: begin
              if (bit_cnt == '0) begin
                state <= S_IDLE;
                done  <= 1'b1;
                if (rd_q) rd_data <= rx_val;
                no_phy <= rd_q && (reg_q == 5'd1) &&
                          ((rx_val == 16'hFFFF) || (rx_val == 16'h0000));
              end else bit_cnt <= bit_cnt - 1'b1;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R1
  AST_PRE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o)); // R2
  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7
  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_NO_PHY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(no_phy) |-> done); // R10

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb_top;
  localparam int SYS_NS  = 10;
  localparam int MIN_NS  = 25;
  localparam int PRE     = 32;
  localparam int HALF    = (MIN_NS + SYS_NS - 1) / SYS_NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd_wr = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy, done, no_phy, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mdio_master #(.SYS_PERIOD_NS(SYS_NS), .MIN_HALF_NS(MIN_NS), .PRE_LEN(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .no_phy(no_phy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  // PHY model and line monitors
  int rise_cnt = 0, base = 0;
  logic cap_o [0:127];
  logic cap_oe[0:127];
  logic [15:0] resp = '0;
  logic resp_rd = 1'b0;
  logic drv = 1'b1;
  assign mdio_i = drv;

  always @(posedge mdc) begin
    if (rise_cnt - base >= 0 && rise_cnt - base < 128) begin
      cap_o[rise_cnt - base]  = mdio_o;
      cap_oe[rise_cnt - base] = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge clk) begin
    int j;
    j = rise_cnt - base - (PRE + 16);
    if (!resp_rd || j < 0 || j > 18) drv <= 1'b1;
    else if (j == 0) drv <= 1'b1;
    else if (j == 1) drv <= 1'b0;
    else if (j == 18) drv <= 1'b1;
    else drv <= resp[17 - j];
  end

  int cyc = 0, last_chg = 0, bad_iv = 0, bad_hi = 0;
  logic last_ok = 1'b0, p_mdc = 1'b0, p_o = 1'b1, p_oe = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (busy && mdc != p_mdc) begin
      if (last_ok && (cyc - last_chg != HALF)) bad_iv = bad_iv + 1;
      last_chg = cyc;
      last_ok = 1'b1;
    end
    if (!busy) last_ok = 1'b0;
    if (mdc && p_mdc && (mdio_o != p_o || mdio_oe != p_oe)) bad_hi = bad_hi + 1;
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] wd, input logic [15:0] rsp, input bit mid);
    logic [31:0] cmd;
    int ncmd, nrel, total, wait_n, done_n, iv0, hi0;
    bit pre_ok, cmd_ok, rel_ok, to;
    logic [15:0] got;
    logic np;
    iv0 = bad_iv; hi0 = bad_hi;
    cmd  = rd ? {4'b1101, 2'b10, pa, ra, 16'h0} : {4'b0101, pa, ra, 2'b10, wd};
    ncmd = rd ? 16 : 32;
    nrel = rd ? 19 : 2;
    total = PRE + ncmd + nrel;
    @(negedge clk);
    base = rise_cnt;
    resp = rsp; resp_rd = rd;
    rd_wr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    wait_n = 0; done_n = 0; to = 0; got = '0; np = 1'b0;
    while (done_n == 0) begin
      @(negedge clk);
      wait_n++;
      if (mid && wait_n == 40) begin
        start = 1'b1; rd_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
      end else start = 1'b0;
      if (done) begin
        done_n++; got = rd_data; np = no_phy;
        chk(busy == 1'b0, "R8", "busy at done", busy, 0);
      end
      if (wait_n > 5000) begin to = 1; done_n = 1; end
    end
    chk(!to, "R8", "done timeout", wait_n, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
    chk(rise_cnt - base == total, mid ? "R9" : "R4", "clock count", rise_cnt - base, total);
    pre_ok = 1; cmd_ok = 1; rel_ok = 1;
    for (int i = 0; i < PRE; i++) if (!(cap_oe[i] && cap_o[i])) pre_ok = 0;
    for (int i = 0; i < ncmd; i++)
      if (!cap_oe[PRE + i] || cap_o[PRE + i] !== cmd[31 - i]) cmd_ok = 0;
    for (int i = 0; i < nrel; i++) if (cap_oe[PRE + ncmd + i] !== 1'b0) rel_ok = 0;
    chk(pre_ok, "R2", "preamble", pre_ok, 1);
    chk(cmd_ok, rd ? "R3" : "R5", mid ? "command R9" : "command", cmd_ok, 1);
    chk(rel_ok, rd ? "R4" : "R5", "released tail", rel_ok, 1);
    if (rd) chk(got == rsp, mid ? "R9" : "R4", "read data", got, rsp);
    chk(np == (rd && ra == 5'd1 && (rsp == 16'hFFFF || rsp == 16'h0000)),
        "R10", "no_phy", np, rd && ra == 5'd1 && (rsp == 16'hFFFF || rsp == 16'h0000));
    chk(bad_iv == iv0, "R6", "half period", bad_iv - iv0, 0);
    chk(bad_hi == hi0, "R7", "change while mdc high", bad_hi - hi0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !busy && !done && !no_phy && rd_data == 0,
        "R1", "reset outputs", {mdc, mdio_oe, busy, done, no_phy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mdc && !mdio_oe, "R1", "idle quiet", {mdc, mdio_oe}, 0);
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 3; r++) begin
        logic [4:0] pa, ra;
        logic [15:0] d;
        pa = 5'((p * 11 + 3) % 32);
        ra = 5'((r * 13 + 2) % 32);
        d  = 16'((p * 9029 + r * 4441 + 16'h5A3C) % 65536);
        txn(1'b0, pa, ra, d, 16'h0, 1'b0);
        txn(1'b1, pa, ra, 16'h0, d ^ 16'h8001, 1'b0);
      end
    end
    txn(1'b1, 5'd0, 5'd1, 16'h0, 16'hFFFF, 1'b0);   // R10 all ones
    txn(1'b1, 5'd0, 5'd1, 16'h0, 16'h0000, 1'b0);   // R10 all zeros
    txn(1'b1, 5'd7, 5'd2, 16'h0, 16'hFFFF, 1'b0);   // R10 other register
    txn(1'b1, 5'd0, 5'd1, 16'h0, 16'h0000, 1'b0);
    txn(1'b0, 5'd0, 5'd1, 16'hFFFF, 16'h0, 1'b0);   // R10 cleared by write
    txn(1'b1, 5'd31, 5'd1, 16'h0, 16'h7FFE, 1'b0);
    txn(1'b1, 5'd19, 5'd6, 16'h0, 16'hC3A5, 1'b1);  // R9 read with stray start
    txn(1'b0, 5'd12, 5'd29, 16'h1E2D, 16'h0, 1'b1); // R9 write with stray start
    repeat (10) @(negedge clk);
    chk(!busy && !mdc && !mdio_oe, "R1", "idle after runs", {busy, mdc, mdio_oe}, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule